// File: doc/BRIEF.md
# Security Lock and Address Configuration Control

This block keeps the protection and configuration state of a serial nonvolatile memory and judges every byte that a bus front end hands to it. The front end reports the start of each command (its target region and read/write direction), every data byte received during a write, and the stop condition. For each written byte the block answers with an acknowledge or a refusal. At the stop it decides whether the buffered write may be committed. Address counting, bus timing and the storage array stay outside.

The state held here is a hardware write-protect input, a one-way lock bit for the security sector, a four-bit device address setting, and a volatile enable flag. The setting has three select bits and an "answer to any select" bit. The enable flag must be armed by the command directly before a configuration write. The block also forms the bytes that the front end shifts out for lock-status and configuration reads, and it compares an incoming three-bit device select against the stored setting.

Region codes on `cmd_region`: 0 main array, 1 security sector, 2 lock register, 3 unique ID, 4 configuration, 5 configuration write-enable.

Top module: `prot_cfg_ctrl`

## Requirements
- R1: After reset the lock bit is 0, the configuration bits are 0001 (select bits 000, any-select bit 1), the enable flag is 0, and neither `commit` nor `ack_valid` is high.
- R2: `sel_match` is 1 when the any-select bit (`cfg_bits[0]`) is 1. Otherwise it is 1 only when `dev_sel` equals `cfg_bits[3:1]`.
- R3: Main-array write bytes are always acknowledged. One cycle after a stop that ends a write with at least one accepted byte, `commit` pulses with `commit_region` = 0, unless `wp_in` is high at the stop; in that case no commit occurs.
- R4: A committed lock-region write whose data byte has bit 1 set sets the lock bit in the same cycle as the commit pulse. A byte with bit 1 clear, or a stop with `wp_in` high, leaves the lock bit at 0.
- R5: While the lock bit is 1, bytes written to the security sector or the lock region are refused (`ack` = 0) and no commit follows. The lock bit never returns to 0 except through reset.
- R6: `lock_rdbyte` has the lock bit at bit 1 and zeros in all other bits.
- R7: A write command to region 5 sets `wren_flag` one cycle after `cmd_start`. The next command start of any kind clears it.
- R8: Configuration-write bytes are acknowledged only when the previous command was a write to region 5. An accepted byte's bits 7:4 become `cfg_bits` (C2, C1, C0, any-select) in the commit cycle. Otherwise the bytes are refused and `cfg_bits` keeps its value.
- R9: `cfg_rdbyte` carries `cfg_bits` in bits 7:4 and ones in bits 3:0.
- R10: Bytes written to the unique-ID region are refused and never lead to a commit.
- R11: A command start arriving before the stop abandons the bytes of the interrupted write, so the later stop yields no commit.
- R12: `ack_valid` pulses exactly one cycle after each `data_valid` that falls inside a write command. Bytes during a read command give no `ack_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_in | input | 1 | Hardware write protect, high inhibits commits |
| cmd_start | input | 1 | Pulse: a command begins |
| cmd_write | input | 1 | Direction of the starting command, 1 = write |
| cmd_region | input | 3 | Target region of the starting command |
| data_valid | input | 1 | Pulse: a data byte was received |
| data_byte | input | 8 | Received data byte |
| stop_evt | input | 1 | Pulse: stop condition seen |
| dev_sel | input | 3 | Select bits from the incoming device address |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge the byte, 0 = refuse |
| commit | output | 1 | Pulse: start the write of the buffered command |
| commit_region | output | 3 | Region of the committed write |
| lock_bit | output | 1 | Security-sector lock state |
| cfg_bits | output | 4 | C2, C1, C0, any-select |
| wren_flag | output | 1 | Configuration write-enable flag |
| sel_match | output | 1 | Device select matches the stored setting |
| lock_rdbyte | output | 8 | Lock-status read byte |
| cfg_rdbyte | output | 8 | Configuration read byte |

## Verification
Each result has a fixed latency. The acknowledge decision is due one cycle after its byte. The commit pulse and the lock and configuration updates are due one cycle after the stop. The enable flag follows its command start by one cycle. The select match and the two read bytes follow the registers combinationally. The bench drives every pulse from one falling edge to the next and reads results at the falling edge after the rising edge that samples them. A scoreboard queue holds the expected acknowledge for each byte, and a monitor pops one entry for every `ack_valid`. Any acknowledge that arrives with no matching entry counts as a failure.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  typedef enum logic [2:0] {
    RG_MAIN = 3'd0,
    RG_SEC  = 3'd1,
    RG_LOCK = 3'd2,
    RG_UID  = 3'd3,
    RG_CFG  = 3'd4,
    RG_WREN = 3'd5
  } region_e;
endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/prot_wren_guard.sv
module prot_wren_guard
  import prot_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_write,
  input  logic [2:0] cmd_region,
  output logic       wren_flag,
  output logic       cfg_ok
);
  logic wren_q, wren_d;
  logic ok_q, ok_d;

  always_comb begin
    wren_d = wren_q;
    ok_d   = ok_q;
    if (cmd_start) begin
      // every command start consumes the flag; only a write to the enable
      // register re-arms it
      wren_d = cmd_write && (cmd_region == RG_WREN);
      ok_d   = wren_q && cmd_write && (cmd_region == RG_CFG);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      wren_q <= wren_d;
      ok_q   <= ok_d;
    end
  end

  assign wren_flag = wren_q;
  assign cfg_ok    = ok_q;
endmodule

// File: rtl/prot_byte_judge.sv
module prot_byte_judge
  import prot_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 4,
  parameter int LOCK_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_in,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [2:0]        cmd_region,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              stop_evt,
  input  logic              lock_bit,
  input  logic              cfg_ok,
  output logic              ack_valid,
  output logic              ack,
  output logic              commit_go,
  output logic [2:0]        commit_sel,
  output logic [CFG_W-1:0]  staged_cfg,
  output logic              commit,
  output logic [2:0]        commit_region
);
  localparam int CFG_LSB = DATA_W - CFG_W;

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  region_e          reg_q, reg_d;
  logic             pend_q, pend_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             av_q, av_d;
  logic             ak_q, ak_d;
  logic             cm_q, cm_d;
  logic [2:0]       cr_q, cr_d;

  logic accept, stage, byte_hit;

  always_comb begin
    accept = 1'b0;
    stage  = 1'b0;
    case (reg_q)
      RG_MAIN: begin accept = 1'b1;     stage = 1'b1;     end
      RG_SEC:  begin accept = !lock_bit; stage = !lock_bit; end
      RG_LOCK: begin
        accept = !lock_bit;
        stage  = !lock_bit && data_byte[LOCK_POS];
      end
      RG_CFG:  begin accept = cfg_ok;   stage = cfg_ok;   end
      RG_WREN: begin accept = 1'b1;     stage = 1'b0;     end
      default: begin accept = 1'b0;     stage = 1'b0;     end
    endcase
  end

  assign byte_hit  = data_valid && act_q && wr_q && !cmd_start;
  assign commit_go = stop_evt && !cmd_start && act_q && wr_q && pend_q && !wp_in;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    reg_d  = reg_q;
    pend_d = pend_q;
    cfg_d  = cfg_q;
    if (cmd_start) begin
      act_d  = 1'b1;
      wr_d   = cmd_write;
      reg_d  = region_e'(cmd_region);
      pend_d = 1'b0;
    end else if (stop_evt) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (byte_hit && stage) begin
      pend_d = 1'b1;
      if (reg_q == RG_CFG) cfg_d = data_byte[DATA_W-1:CFG_LSB];
    end
    av_d = byte_hit;
    ak_d = byte_hit && accept;
    cm_d = commit_go;
    cr_d = commit_go ? reg_q : cr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      reg_q  <= RG_MAIN;
      pend_q <= 1'b0;
      cfg_q  <= '0;
      av_q   <= 1'b0;
      ak_q   <= 1'b0;
      cm_q   <= 1'b0;
      cr_q   <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      reg_q  <= reg_d;
      pend_q <= pend_d;
      cfg_q  <= cfg_d;
      av_q   <= av_d;
      ak_q   <= ak_d;
      cm_q   <= cm_d;
      cr_q   <= cr_d;
    end
  end

  assign ack_valid     = av_q;
  assign ack           = ak_q;
  assign commit        = cm_q;
  assign commit_region = cr_q;
  assign commit_sel    = reg_q;
  assign staged_cfg    = cfg_q;
endmodule

// File: rtl/prot_nv_regs.sv
module prot_nv_regs
  import prot_cfg_pkg::*;
#(
  parameter int             CFG_W       = 4,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 4'b0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_go,
  input  logic [2:0]       commit_sel,
  input  logic [CFG_W-1:0] staged_cfg,
  output logic             lock_bit,
  output logic [CFG_W-1:0] cfg_bits
);
  logic             lock_q, lock_d, lock_en;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  assign lock_en = commit_go && (commit_sel == RG_LOCK);
  assign cfg_en  = commit_go && (commit_sel == RG_CFG);

  always_comb begin
    lock_d = lock_q | lock_en;
    cfg_d  = cfg_en ? staged_cfg : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cfg_q  <= CFG_DEFAULT;
    end else begin
      if (lock_en) lock_q <= lock_d;
      if (cfg_en)  cfg_q  <= cfg_d;
    end
  end

  assign lock_bit = lock_q;
  assign cfg_bits = cfg_q;
endmodule

// File: rtl/prot_cfg_ctrl.sv
module prot_cfg_ctrl
  import prot_cfg_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               CFG_W       = 4,
  parameter int               LOCK_POS    = 1,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 4'b0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_in,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [2:0]        cmd_region,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              stop_evt,
  input  logic [CFG_W-2:0]  dev_sel,
  output logic              ack_valid,
  output logic              ack,
  output logic              commit,
  output logic [2:0]        commit_region,
  output logic              lock_bit,
  output logic [CFG_W-1:0]  cfg_bits,
  output logic              wren_flag,
  output logic              sel_match,
  output logic [DATA_W-1:0] lock_rdbyte,
  output logic [DATA_W-1:0] cfg_rdbyte
);
  localparam int SEL_W  = CFG_W - 1;
  localparam int FILL_W = DATA_W - CFG_W;

  logic             rst_n_i;
  logic             cfg_ok;
  logic             commit_go;
  logic [2:0]       commit_sel;
  logic [CFG_W-1:0] staged_cfg;
  logic [SEL_W-1:0] sel_eq;

  prot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  prot_wren_guard u_guard (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_region(cmd_region),
    .wren_flag(wren_flag), .cfg_ok(cfg_ok)
  );

  prot_byte_judge #(.DATA_W(DATA_W), .CFG_W(CFG_W), .LOCK_POS(LOCK_POS)) u_judge (
    .clk(clk), .rst_n(rst_n_i), .wp_in(wp_in),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_region(cmd_region),
    .data_valid(data_valid), .data_byte(data_byte), .stop_evt(stop_evt),
    .lock_bit(lock_bit), .cfg_ok(cfg_ok),
    .ack_valid(ack_valid), .ack(ack),
    .commit_go(commit_go), .commit_sel(commit_sel), .staged_cfg(staged_cfg),
    .commit(commit), .commit_region(commit_region)
  );

  prot_nv_regs #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_nv (
    .clk(clk), .rst_n(rst_n_i),
    .commit_go(commit_go), .commit_sel(commit_sel), .staged_cfg(staged_cfg),
    .lock_bit(lock_bit), .cfg_bits(cfg_bits)
  );

  // select comparison: cfg_bits[0] is the any-select bit, the rest align with dev_sel
  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    assign sel_eq[i] = (dev_sel[i] == cfg_bits[i+1]);
  end
  assign sel_match = cfg_bits[0] | (&sel_eq);

  for (genvar b = 0; b < DATA_W; b++) begin : g_lockrd
    if (b == LOCK_POS) begin : g_bit
      assign lock_rdbyte[b] = lock_bit;
    end else begin : g_zero
      assign lock_rdbyte[b] = 1'b0;
    end
  end

  assign cfg_rdbyte = {cfg_bits, {FILL_W{1'b1}}};
endmodule

// File: rtl/prot_cfg_ctrl_chk.sv
module prot_cfg_ctrl_chk
  import prot_cfg_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp_in,
  input logic             cmd_start,
  input logic             cmd_write,
  input logic [2:0]       cmd_region,
  input logic             data_valid,
  input logic             stop_evt,
  input logic             ack_valid,
  input logic             commit,
  input logic [2:0]       commit_region,
  input logic             lock_bit,
  input logic [CFG_W-1:0] cfg_bits,
  input logic             wren_flag
);
  a_r3_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_evt));

  a_r3_wp_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(wp_in));

  a_r4_lock_rise_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_bit) |-> (commit && commit_region == RG_LOCK));

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit |=> lock_bit);

  a_r7_wren_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !(cmd_write && cmd_region == RG_WREN)) |=> !wren_flag);

  a_r8_cfg_change_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bits) |-> (commit && commit_region == RG_CFG));

  a_r12_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(data_valid));
endmodule

bind prot_cfg_ctrl prot_cfg_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_in(wp_in),
  .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_region(cmd_region),
  .data_valid(data_valid), .stop_evt(stop_evt),
  .ack_valid(ack_valid), .commit(commit), .commit_region(commit_region),
  .lock_bit(lock_bit), .cfg_bits(cfg_bits), .wren_flag(wren_flag)
);

// File: tb/prot_cfg_ctrl_test.sv
module prot_cfg_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wp_in, cmd_start, cmd_write, data_valid, stop_evt;
  logic [2:0] cmd_region, dev_sel;
  logic [7:0] data_byte;
  logic       ack_valid, ack, commit, lock_bit, wren_flag, sel_match;
  logic [2:0] commit_region;
  logic [3:0] cfg_bits;
  logic [7:0] lock_rdbyte, cfg_rdbyte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit          exp_ack_q[$];
  string       exp_tag_q[$];

  always #2 clk = ~clk;

  prot_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wp_in(wp_in),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_region(cmd_region),
    .data_valid(data_valid), .data_byte(data_byte), .stop_evt(stop_evt),
    .dev_sel(dev_sel),
    .ack_valid(ack_valid), .ack(ack), .commit(commit), .commit_region(commit_region),
    .lock_bit(lock_bit), .cfg_bits(cfg_bits), .wren_flag(wren_flag),
    .sel_match(sel_match), .lock_rdbyte(lock_rdbyte), .cfg_rdbyte(cfg_rdbyte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected acknowledge per ack_valid
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ack_valid) begin
        if (exp_ack_q.size() == 0) begin
          check(1'b0, "R12 unexpected ack_valid", 1, 0);
        end else begin
          bit    e;
          string t;
          e = exp_ack_q.pop_front();
          t = exp_tag_q.pop_front();
          check(ack == e, t, ack, e);
        end
      end
    end
  end

  task automatic start_cmd(input logic [2:0] rg, input logic wr);
    @(negedge clk);
    cmd_start = 1'b1; cmd_region = rg; cmd_write = wr;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit expect_ack, input bit e, input string tag);
    @(negedge clk);
    data_valid = 1'b1; data_byte = b;
    if (expect_ack) begin
      exp_ack_q.push_back(e);
      exp_tag_q.push_back(tag);
    end
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic stop_chk(input bit e_commit, input logic [2:0] e_rg, input string tag);
    @(negedge clk);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    check(commit == e_commit, tag, commit, e_commit);
    if (e_commit) check(commit_region == e_rg, {tag, " region"}, commit_region, e_rg);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wp_in = 1'b0; cmd_start = 1'b0; cmd_write = 1'b0;
    cmd_region = 3'd0; data_valid = 1'b0; data_byte = 8'h00; stop_evt = 1'b0;
    dev_sel = 3'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R6/R9 read bytes
    check(lock_bit == 1'b0, "R1 lock after reset", lock_bit, 0);
    check(cfg_bits == 4'b0001, "R1 cfg after reset", cfg_bits, 1);
    check(wren_flag == 1'b0, "R1 wren after reset", wren_flag, 0);
    check(!commit && !ack_valid, "R1 no commit/ack after reset", {commit, ack_valid}, 0);
    check(lock_rdbyte == 8'h00, "R6 lock read unlocked", lock_rdbyte, 8'h00);
    check(cfg_rdbyte == 8'h1F, "R9 cfg read default", cfg_rdbyte, 8'h1F);
    // R2 any-select
    #1 check(sel_match == 1'b1, "R2 any-select default", sel_match, 1);

    // R3 main write, commit after stop
    start_cmd(3'd0, 1'b1);
    send_byte(8'h3C, 1, 1, "R3 main byte0 ack");
    send_byte(8'hC3, 1, 1, "R3 main byte1 ack");
    stop_chk(1, 3'd0, "R3 main commit");
    @(negedge clk);
    check(commit == 1'b0, "R3 commit single pulse", commit, 0);

    // R3 write protect: acked, no commit
    wp_in = 1'b1;
    start_cmd(3'd0, 1'b1);
    send_byte(8'h55, 1, 1, "R3 main ack under wp");
    stop_chk(0, 3'd0, "R3 wp suppresses commit");
    wp_in = 1'b0;

    // R12 read command gives no ack
    start_cmd(3'd0, 1'b0);
    send_byte(8'hAA, 0, 0, "");
    stop_chk(0, 3'd0, "R12 read no commit");

    // R10 unique-ID write refused
    start_cmd(3'd3, 1'b1);
    send_byte(8'hFF, 1, 0, "R10 uid byte refused");
    stop_chk(0, 3'd0, "R10 uid no commit");

    // R4 lock byte without bit1
    start_cmd(3'd2, 1'b1);
    send_byte(8'hFD, 1, 1, "R4 lock byte bit1=0 ack");
    stop_chk(0, 3'd0, "R4 bit1=0 no commit");
    check(lock_bit == 1'b0, "R4 lock stays 0", lock_bit, 0);

    // R4 lock blocked by write protect
    wp_in = 1'b1;
    start_cmd(3'd2, 1'b1);
    send_byte(8'h02, 1, 1, "R4 lock byte under wp ack");
    stop_chk(0, 3'd0, "R4 wp blocks lock");
    wp_in = 1'b0;
    check(lock_bit == 1'b0, "R4 lock 0 after wp", lock_bit, 0);

    // security sector writable while unlocked
    start_cmd(3'd1, 1'b1);
    send_byte(8'h11, 1, 1, "R5 sec ack unlocked");
    stop_chk(1, 3'd1, "R5 sec commit unlocked");

    // R4 set lock
    start_cmd(3'd2, 1'b1);
    send_byte(8'h02, 1, 1, "R4 lock byte ack");
    stop_chk(1, 3'd2, "R4 lock commit");
    check(lock_bit == 1'b1, "R4 lock set", lock_bit, 1);
    check(lock_rdbyte == 8'h02, "R6 lock read locked", lock_rdbyte, 8'h02);

    // R5 locked: refuse sec and lock bytes
    start_cmd(3'd1, 1'b1);
    send_byte(8'h22, 1, 0, "R5 sec refused locked");
    stop_chk(0, 3'd0, "R5 sec no commit locked");
    start_cmd(3'd2, 1'b1);
    send_byte(8'h00, 1, 0, "R5 lock refused locked");
    stop_chk(0, 3'd0, "R5 lock no commit locked");
    check(lock_bit == 1'b1, "R5 lock remains set", lock_bit, 1);

    // R8 configuration write without enable
    start_cmd(3'd4, 1'b1);
    send_byte(8'hA0, 1, 0, "R8 cfg refused no enable");
    stop_chk(0, 3'd0, "R8 cfg no commit");
    check(cfg_bits == 4'b0001, "R8 cfg unchanged", cfg_bits, 1);

    // R7 enable then R8 configuration write
    start_cmd(3'd5, 1'b1);
    check(wren_flag == 1'b1, "R7 wren set", wren_flag, 1);
    stop_chk(0, 3'd0, "R7 wren no commit");
    start_cmd(3'd4, 1'b1);
    check(wren_flag == 1'b0, "R7 wren cleared by next cmd", wren_flag, 0);
    send_byte(8'hA7, 1, 1, "R8 cfg ack enabled");
    stop_chk(1, 3'd4, "R8 cfg commit");
    check(cfg_bits == 4'hA, "R8 cfg updated", cfg_bits, 4'hA);
    check(cfg_rdbyte == 8'hAF, "R9 cfg read updated", cfg_rdbyte, 8'hAF);

    // R2 exact select now that any-select is 0 (C2 C1 C0 = 101)
    dev_sel = 3'd5;
    #1 check(sel_match == 1'b1, "R2 select equal", sel_match, 1);
    dev_sel = 3'd4;
    #1 check(sel_match == 1'b0, "R2 select differ", sel_match, 0);

    // R8 enable consumed by an intervening read
    start_cmd(3'd5, 1'b1);
    stop_chk(0, 3'd0, "R7 wren cmd no commit");
    start_cmd(3'd0, 1'b0);
    stop_chk(0, 3'd0, "R7 read cmd");
    start_cmd(3'd4, 1'b1);
    send_byte(8'h10, 1, 0, "R8 cfg refused after read");
    stop_chk(0, 3'd0, "R8 no commit after read");
    check(cfg_bits == 4'hA, "R8 cfg kept", cfg_bits, 4'hA);

    // R11 restart abandons pending bytes
    start_cmd(3'd0, 1'b1);
    send_byte(8'h77, 1, 1, "R11 main byte ack");
    start_cmd(3'd0, 1'b1);
    stop_chk(0, 3'd0, "R11 restart abandons write");

    repeat (3) @(negedge clk);
    check(exp_ack_q.size() == 0, "R12 all acks seen", exp_ack_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule